// File: doc/BRIEF.md
# Prescaled Up/Down Interval Timer

A 16-bit general-purpose timer attached to a simple register bus. Software chooses the division ratio, the count direction and whether the timer runs once or repeatedly. It then starts and stops the timer with a command register. The counter steps once per prescaled tick. When it wraps it raises an event flag: an overflow when counting up and reaches the reload value, or an underflow when counting down and passes zero. Each flag can be enabled onto a single level-sensitive interrupt line.

Typical use falls into two patterns. In the first, the timer counts up freely as a time base that software samples. In the second, it counts down from a reload value to produce periodic or single-shot events. The counter may be written at any time, which lets software arm a one-shot delay. Bus writes take effect on the clock edge at which the write strobe is high. Reads are combinational while the read strobe is high.

The sequencing is a two-state machine. In STOPPED, the counter and the prescaler are idle. In RUNNING, the prescaler advances and each tick steps the counter. The transitions are as follows. "start" goes from STOPPED to RUNNING on a command write with only the start bit set. "halt" goes from RUNNING to STOPPED on a command write with the stop bit set. "expire" goes from RUNNING to STOPPED on an underflow while single-shot is enabled, unless a start command arrives in the same cycle.

Top module: `tmr_updown`

## Requirements
- R1: After reset the control, reload, counter, enable and flag registers read 0, the timer is STOPPED and the interrupt output is low.
- R2: A write to offset 0x04 with bit 0 set starts the timer. A write with bit 1 set stops it, and stop wins when both bits are set. While stopped, the counter holds its value. Offset 0x04 reads 0.
- R3: Control bits 27:24 hold a code k. While RUNNING, a tick occurs every 2^k clock cycles, and the first tick falls on the 2^k-th edge after the start edge. Control bits 17:16 select the tick source: value 0 uses the prescaled clock, and any other value produces no ticks.
- R4: When control bits 1:0 are not 1, each tick adds one to the counter. A tick with the counter equal to the reload value (offset 0x1C) wraps the counter to 0 and sets flag bit 0 (overflow).
- R5: When control bits 1:0 equal 1, each tick subtracts one from the counter. A tick at 0 loads the reload value and sets flag bit 1 (underflow). Without single-shot, this repeats indefinitely.
- R6: With control bit 4 set, an underflow also moves the timer to STOPPED, and the counter keeps the reload value.
- R7: A write to offset 0x24 loads the counter. The write takes precedence over a tick in the same cycle.
- R8: Flags read at offset 0x10, and writes there have no effect. Writing ones to offset 0x14 sets the matching flags, and writing ones to offset 0x18 clears them. A hardware event in the same cycle as a clear leaves that flag set.
- R9: The interrupt output is high exactly when some flag bit and the same bit of the enable register (offset 0x0C, bits 1:0) are both 1.
- R10: Read data is 0 when the read strobe is low. Offsets 0x04, 0x14, 0x18 and undefined offsets read 0. Offset 0x00 reads back the code, source, single-shot and direction fields at their bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, OR of enabled flags |

## Verification
The assertions check on every cycle the properties that each hold over a single step. A stop command or a single-shot underflow leaves the timer STOPPED. A stopped counter holds unless it is written. A down-count tick away from zero decrements by exactly one. Every wrap event sets its flag. The read bus stays at zero without a read strobe. The bench's scenarios cover what needs a sequence of steps: prescaler spacing up to divide-by-1024, periodic reload over several underflows, the clash between a counter write and a tick, hardware events winning over a clear, and the source selector silencing the counter. Its reference model checks the interrupt line and the counter against every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CODE_W = 4;
    localparam int SRC_W  = 2;
    localparam int DIR_W  = 2;
    localparam int NFLAG  = 2;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_FLG  = 8'h10;
    localparam logic [7:0] OFS_FSET = 8'h14;
    localparam logic [7:0] OFS_FCLR = 8'h18;
    localparam logic [7:0] OFS_TOP  = 8'h1C;
    localparam logic [7:0] OFS_CNT  = 8'h24;

    localparam int CODE_LSB = 24;
    localparam int SRC_LSB  = 16;
    localparam int OS_BIT   = 4;
    localparam int DIR_LSB  = 0;

    localparam int CMD_GO   = 0;
    localparam int CMD_HALT = 1;

    localparam int FLG_OVF  = 0;
    localparam int FLG_UNF  = 1;

    typedef enum logic {
        TMR_STOPPED = 1'b0,
        TMR_RUNNING = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [SRC_W-1:0]  src;
        logic              single;
        logic [DIR_W-1:0]  dir;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int CODE_W = 4,
    parameter int SRC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    input  logic [SRC_W-1:0]  src,
    output logic              tick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb mask = ~({PRE_W{1'b1}} << code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (run) pre_q <= pre_q + 1'b1;
        else          pre_q <= '0;
    end

    assign tick = run && (src == '0) && ((pre_q & mask) == mask);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          go,
    input  logic          halt,
    input  logic          single,
    input  logic          down,
    input  logic [CW-1:0] top,
    input  logic          cnt_load,
    input  logic [CW-1:0] cnt_wdata,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          ovf_evt,
    output logic          unf_evt
);
    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ovf_evt = tick && !down && (cnt_q == top);
        unf_evt = tick && down && (cnt_q == '0);
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_STOPPED: begin
                if (go && !halt) state_d = TMR_RUNNING;
            end
            TMR_RUNNING: begin
                if (halt)                          state_d = TMR_STOPPED;
                else if (unf_evt && single && !go) state_d = TMR_STOPPED;
            end
            default: state_d = TMR_STOPPED;
        endcase
        if (cnt_load) begin
            cnt_d = cnt_wdata;
        end else if (tick) begin
            if (down) cnt_d = (cnt_q == '0) ? top : cnt_q - 1'b1;
            else      cnt_d = (cnt_q == top) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign running = (state_q == TMR_RUNNING);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] hw_set,
    input  logic [NF-1:0] sw_set,
    input  logic [NF-1:0] sw_clr,
    input  logic [NF-1:0] ien,
    output logic [NF-1:0] flags,
    output logic          irq
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= hw_set[i] | ((f_q | sw_set[i]) & ~sw_clr[i]);
        end
        assign flags[i] = f_q;
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    tmr_ctrl_t         ctrl_q;
    logic [CNT_W-1:0]  top_q;
    logic [NFLAG-1:0]  ien_q;
    logic [CNT_W-1:0]  cnt;
    logic [NFLAG-1:0]  flags;
    logic              running, tick, ovf_evt, unf_evt;
    logic              single_en, count_down;
    logic              wr_ctrl, wr_cmd, wr_ien, wr_fset, wr_fclr, wr_top, wr_cnt;
    logic [DATA_W-1:0] rd_mux;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
    assign wr_fset = bus_wr && (bus_addr == ADDR_W'(OFS_FSET));
    assign wr_fclr = bus_wr && (bus_addr == ADDR_W'(OFS_FCLR));
    assign wr_top  = bus_wr && (bus_addr == ADDR_W'(OFS_TOP));
    assign wr_cnt  = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            top_q  <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.code   <= bus_wdata[CODE_LSB +: CODE_W];
                ctrl_q.src    <= bus_wdata[SRC_LSB +: SRC_W];
                ctrl_q.single <= bus_wdata[OS_BIT];
                ctrl_q.dir    <= bus_wdata[DIR_LSB +: DIR_W];
            end
            if (wr_top) top_q <= bus_wdata[CNT_W-1:0];
            if (wr_ien) ien_q <= bus_wdata[NFLAG-1:0];
        end
    end

    assign single_en  = ctrl_q.single;
    assign count_down = (ctrl_q.dir == DIR_W'(1));

    tmr_tick_gen #(.CODE_W(CODE_W), .SRC_W(SRC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .code  (ctrl_q.code),
        .src   (ctrl_q.src),
        .tick  (tick)
    );

    tmr_core #(.CW(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go        (wr_cmd && bus_wdata[CMD_GO]),
        .halt      (wr_cmd && bus_wdata[CMD_HALT]),
        .single    (single_en),
        .down      (count_down),
        .top       (top_q),
        .cnt_load  (wr_cnt),
        .cnt_wdata (bus_wdata[CNT_W-1:0]),
        .cnt       (cnt),
        .running   (running),
        .ovf_evt   (ovf_evt),
        .unf_evt   (unf_evt)
    );

    tmr_flags #(.NF(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set ({unf_evt, ovf_evt}),
        .sw_set (wr_fset ? bus_wdata[NFLAG-1:0] : '0),
        .sw_clr (wr_fclr ? bus_wdata[NFLAG-1:0] : '0),
        .ien    (ien_q),
        .flags  (flags),
        .irq    (irq)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                rd_mux[CODE_LSB +: CODE_W] = ctrl_q.code;
                rd_mux[SRC_LSB +: SRC_W]   = ctrl_q.src;
                rd_mux[OS_BIT]             = ctrl_q.single;
                rd_mux[DIR_LSB +: DIR_W]   = ctrl_q.dir;
            end
            ADDR_W'(OFS_IEN): rd_mux[NFLAG-1:0] = ien_q;
            ADDR_W'(OFS_FLG): rd_mux[NFLAG-1:0] = flags;
            ADDR_W'(OFS_TOP): rd_mux[CNT_W-1:0] = top_q;
            ADDR_W'(OFS_CNT): rd_mux[CNT_W-1:0] = cnt;
            default:          rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/tmr_updown_chk.sv
module tmr_updown_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              running,
    input logic              tick,
    input logic              ovf_evt,
    input logic              unf_evt,
    input logic              single_en,
    input logic              count_down,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        flags
);
    logic cmd_wr, cnt_wr;
    assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(8'h04));
    assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(8'h24));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) && !running && (flags == '0));

    // R2
    stop_cmd_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[1]) |=> !running);

    // R2
    stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt));

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_down && (cnt != '0) && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1));

    // R6
    single_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_evt && single_en && !cmd_wr) |=> !running);

    // R8
    unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> flags[1]);

    // R8
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flags[0]);

    // R10
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind tmr_updown tmr_updown_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .running    (running),
    .tick       (tick),
    .ovf_evt    (ovf_evt),
    .unf_evt    (unf_evt),
    .single_en  (single_en),
    .count_down (count_down),
    .cnt        (cnt),
    .flags      (flags)
);

// File: tb/tb_tmr_updown.sv
`timescale 1ns/1ps
module tb_tmr_updown;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    tmr_updown dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt, m_top, m_pre, m_run, m_code, m_src, m_single, m_dir, m_flags, m_ien;
    int tk, ovf, unf, nc, nrun, npre, nflags;

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_top = 0; m_pre = 0; m_run = 0; m_code = 0; m_src = 0;
            m_single = 0; m_dir = 0; m_flags = 0; m_ien = 0;
        end else begin
            tk  = (m_run != 0) && (m_src == 0) && ((m_pre % (1 << m_code)) == (1 << m_code) - 1);
            ovf = 0; unf = 0; nc = m_cnt;
            if (tk) begin
                if (m_dir == 1) begin
                    if (m_cnt == 0) begin unf = 1; nc = m_top; end
                    else nc = m_cnt - 1;
                end else begin
                    if (m_cnt == m_top) begin ovf = 1; nc = 0; end
                    else nc = (m_cnt + 1) & 'hFFFF;
                end
            end
            nrun = m_run;
            if (unf && m_single) nrun = 0;
            npre = m_run ? (m_pre + 1) % 32768 : 0;
            nflags = m_flags;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: begin
                        m_code = bus_wdata[27:24]; m_src = bus_wdata[17:16];
                        m_single = bus_wdata[4];   m_dir = bus_wdata[1:0];
                    end
                    8'h04: begin
                        if (bus_wdata[0]) nrun = 1;
                        if (bus_wdata[1]) nrun = 0;
                    end
                    8'h0C: m_ien = bus_wdata[1:0];
                    8'h14: nflags = nflags | bus_wdata[1:0];
                    8'h18: nflags = nflags & ~int'(bus_wdata[1:0]);
                    8'h1C: m_top = bus_wdata[15:0];
                    8'h24: nc = bus_wdata[15:0];
                    default: ;
                endcase
            end
            nflags = nflags | (unf << 1) | ovf;
            m_cnt = nc; m_run = nrun; m_pre = npre; m_flags = nflags & 3;
        end
    end

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(cur_req, "irq vs model", irq, ((m_flags & m_ien) != 0) ? 1 : 0);
            if (bus_rd && bus_addr == 8'h24)
                check(cur_req, "cnt vs model", bus_rdata, m_cnt);
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            bus_wr = 0; bus_rd = 1; bus_addr = 8'h24;
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_rd = 1; bus_addr = 8'h24;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req, string what);
        bus_wr = 0; bus_rd = 1; bus_addr = a;
        #1;
        check(req, what, bus_rdata, exp);
        bus_addr = 8'h24;
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        cur_req = "R1";
        rd(8'h00, 0, "R1", "ctrl after reset");
        rd(8'h1C, 0, "R1", "top after reset");
        rd(8'h24, 0, "R1", "cnt after reset");
        rd(8'h0C, 0, "R1", "ien after reset");
        rd(8'h10, 0, "R1", "flags after reset");
        check("R1", "irq after reset", irq, 0);

        // R4 up count with wrap
        cur_req = "R4";
        wr(8'h1C, 3); wr(8'h00, 0); wr(8'h04, 1);
        idle(4);
        rd(8'h24, 0, "R4", "cnt after wrap");
        rd(8'h10, 1, "R4", "overflow flag");
        cur_req = "R2";
        wr(8'h04, 2); idle(2);
        rd(8'h24, 1, "R2", "cnt held after stop");

        // R9 / R8 interrupt and flag aliases
        cur_req = "R9";
        wr(8'h0C, 1);
        check("R9", "irq with ovf enabled", irq, 1);
        wr(8'h18, 1);
        rd(8'h10, 0, "R8", "flag cleared via alias");
        check("R8", "irq after clear", irq, 0);
        wr(8'h14, 2);
        rd(8'h10, 2, "R8", "flag set via alias");
        check("R9", "irq masked unf", irq, 0);
        wr(8'h0C, 3);
        check("R9", "irq unf enabled", irq, 1);
        wr(8'h18, 3);
        wr(8'h10, 3);
        rd(8'h10, 0, "R8", "direct flag write ignored");

        // R5 down periodic with prescaler code 2
        cur_req = "R5";
        wr(8'h00, 32'h0200_0001); wr(8'h1C, 2); wr(8'h24, 1); wr(8'h04, 1);
        idle(3);
        rd(8'h24, 1, "R3", "no tick before 4 cycles");
        idle(17);
        rd(8'h24, 2, "R5", "cnt after two reloads");
        rd(8'h10, 2, "R5", "underflow flag");
        wr(8'h04, 2); idle(2);
        rd(8'h24, 2, "R2", "down cnt held after stop");
        wr(8'h18, 3);

        // R6 single shot
        cur_req = "R6";
        wr(8'h00, 32'h0000_0011); wr(8'h1C, 4); wr(8'h24, 1); wr(8'h04, 1);
        idle(5);
        rd(8'h24, 4, "R6", "cnt parked at reload");
        rd(8'h10, 2, "R6", "underflow flag single");

        // R2 stop wins over start
        cur_req = "R2";
        wr(8'h04, 3); idle(3);
        rd(8'h24, 4, "R2", "start+stop stays stopped");
        wr(8'h18, 3);

        // R3 non-zero source gives no ticks
        cur_req = "R3";
        wr(8'h00, 32'h0001_0000); wr(8'h24, 0); wr(8'h04, 1);
        idle(5);
        rd(8'h24, 0, "R3", "source 1 holds cnt");
        wr(8'h04, 2);

        // R10 readback and silent offsets
        cur_req = "R10";
        wr(8'h00, 32'h0A03_0013);
        rd(8'h00, 32'h0A03_0013, "R10", "ctrl readback");
        wr(8'h00, 0);
        rd(8'h08, 0, "R10", "undefined offset");
        rd(8'h04, 0, "R10", "command reads 0");
        rd(8'h14, 0, "R10", "set alias reads 0");
        rd(8'h18, 0, "R10", "clear alias reads 0");
        bus_rd = 0; bus_addr = 8'h1C; #1;
        check("R10", "rdata with rd low", bus_rdata, 0);
        bus_rd = 1; bus_addr = 8'h24;

        // R7 counter write beats tick
        cur_req = "R7";
        wr(8'h1C, 32'hFFFF); wr(8'h24, 32'h10); wr(8'h04, 1);
        idle(2);
        rd(8'h24, 32'h12, "R7", "running from loaded value");
        wr(8'h24, 32'h100);
        rd(8'h24, 32'h100, "R7", "write wins over tick");
        idle(1);
        rd(8'h24, 32'h101, "R7", "counts on after write");

        // R4 wrap at full range
        cur_req = "R4";
        wr(8'h18, 3);
        wr(8'h24, 32'hFFFE); idle(1);
        rd(8'h24, 32'hFFFF, "R4", "cnt at full range");
        idle(1);
        rd(8'h24, 0, "R4", "wrap from FFFF");
        rd(8'h10, 1, "R4", "overflow at FFFF");

        // R8 hardware set wins over clear
        cur_req = "R8";
        wr(8'h1C, 0); wr(8'h24, 0);
        wr(8'h18, 1);
        rd(8'h10, 1, "R8", "hw event beats clear");
        wr(8'h04, 2);

        // R3 divide by 1024
        cur_req = "R3";
        wr(8'h00, 32'h0A00_0000); wr(8'h1C, 32'hFFFF); wr(8'h24, 0); wr(8'h18, 3);
        wr(8'h04, 1);
        idle(1023);
        rd(8'h24, 0, "R3", "no tick before 1024");
        idle(1);
        rd(8'h24, 1, "R3", "tick at 1024");
        wr(8'h04, 2);

        idle(2);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule